// File: doc/BRIEF.md
# Programmable Routing Switch Box

This block is the switch point where four routing channels meet: west, north, east and south, with `N` single-bit tracks on each side. A fixed topology rule pairs every track on one side with exactly one track on each of the other three sides. That gives six connection types and `6N` programmable switches. A configuration register selects one of four topologies: subset, universal, Wilton-style rotation, or twist. In twist mode a programmable separation factor multiplies the track index, so that tracks that run side by side on entry are spread apart on exit.

Each switch is bidirectional. It is modelled as a pair of directed nets: the inbound track on each end feeds the outbound track on the other end. Every outbound track is the OR of all enabled switches that touch it. A conflict flag reports when more than one enabled switch touches the same outbound track. Configuration and enable writes are registered, and the routing from inbound to outbound tracks is purely combinational. When twist mode is selected with a separation factor that breaks the legality rule, the block clears its valid flag and holds all outputs low.

Track `t` (numbered 1..N) is bit `t-1` of each side bus. Every mapped index is wrapped into 1..N modulo N.

Top module: `sbx_top`

## Requirements
- R1: After reset every switch is disabled, the topology is subset (code 0), `cfg_valid` is 1, and every outbound track and `conflict` are 0.
- R2: A topology or factor write is seen at the outputs only after the next rising clock edge, while a change on an inbound track reaches the outbound tracks in the same cycle.
- R3: Switch type codes are 0=W-E, 1=S-N, 2=W-N, 3=N-E, 4=W-S, 5=S-E, with the first named side holding track t. In subset mode (code 0) every type links track t to track t on the second side, in both directions.
- R4: In universal mode (code 1) types W-N and S-E link t to N-t+1, and all other types link t to t.
- R5: In rotation mode (code 2) W-E and S-N link t to t, W-N to N-t+2, N-E to t+1, W-S to t-1 and S-E to N-t, each wrapped into 1..N.
- R6: In twist mode (code 3) with factor F, W-E and S-N link t to F*t, W-N to F*(N-t)+2, N-E to F*t+1, W-S to F*t-1 and S-E to F*(N-t), each wrapped into 1..N.
- R7: In twist mode a factor F is legal only if 1 < F < N-1 and F does not divide N. With an illegal factor `cfg_valid` is 0, and all outbound tracks and `conflict` are 0. In the other three modes `cfg_valid` is 1.
- R8: In twist mode with a legal factor coprime to N, two W tracks with adjacent numbers never land on E tracks with adjacent numbers.
- R9: Each outbound track is the OR of the inbound tracks at the far end of its enabled switches. `conflict` is 1 exactly when some outbound track has two or more enabled switches.
- R10: Enable writes with type code 6 or 7, or with a track index of N or more, change no switch.
- R11: A switch that is disabled, including one re-written with enable value 0, passes nothing in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load topology and factor |
| cfg_mode | input | 2 | Topology code (0 subset, 1 universal, 2 rotation, 3 twist) |
| cfg_spf | input | SPF_W | Separation factor for twist mode |
| en_we | input | 1 | Load one switch enable |
| en_type | input | 3 | Switch type code |
| en_track | input | TRK_W | Track index on the first side of the type, 0-based |
| en_val | input | 1 | New enable value |
| in_w | input | N | Inbound west tracks |
| in_n | input | N | Inbound north tracks |
| in_e | input | N | Inbound east tracks |
| in_s | input | N | Inbound south tracks |
| out_w | output | N | Outbound west tracks |
| out_n | output | N | Outbound north tracks |
| out_e | output | N | Outbound east tracks |
| out_s | output | N | Outbound south tracks |
| cfg_valid | output | 1 | Configuration legal |
| conflict | output | 1 | Some outbound track has several enabled switches |

## Verification
A configuration write and a change on the inbound tracks can land in the same cycle. The outputs must then show the new inputs routed through the old topology until the clock edge, and through the new topology after it. The bench provokes this by raising `cfg_we` together with a fresh inbound pattern at a falling edge. It checks the outbound tracks before and after the next rising edge against a reference model that follows the old and then the new mapping. The same reference model also judges a large run of random topologies, factors and sparse enable sets, which exercise the conflict flag and the legality rule.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    typedef enum logic [1:0] {
        TOPO_SUBSET = 2'd0,
        TOPO_UNIV   = 2'd1,
        TOPO_ROT    = 2'd2,
        TOPO_TWIST  = 2'd3
    } topo_e;

    localparam int NUM_CT   = 6;
    localparam int NUM_SIDE = 4;

    // side indices
    localparam int SD_W = 0;
    localparam int SD_N = 1;
    localparam int SD_E = 2;
    localparam int SD_S = 3;

    // first side of a connection type (holds track t)
    function automatic int ct_side_a(input int k);
        case (k)
            0, 2, 4: return SD_W;
            1, 5:    return SD_S;
            default: return SD_N;
        endcase
    endfunction

    // second side of a connection type (holds mapped track)
    function automatic int ct_side_b(input int k);
        case (k)
            0, 3, 5: return SD_E;
            1, 2:    return SD_N;
            default: return SD_S;
        endcase
    endfunction

    // wrap a 1-based index into 0..n-1
    function automatic int wrap0(input int v, input int n);
        int r;
        r = (v - 1) % n;
        if (r < 0) r = r + n;
        return r;
    endfunction

    // map 0-based track t0 on side a to 0-based track on side b
    function automatic int map_trk(input topo_e m, input int k, input int t0,
                                   input int spf, input int n);
        int t;
        int s;
        int v;
        t = t0 + 1;
        s = (m == TOPO_TWIST) ? spf : 1;
        v = t;
        case (m)
            TOPO_SUBSET: v = t;
            TOPO_UNIV:   v = (k == 2 || k == 5) ? (n - t + 1) : t;
            default: begin
                case (k)
                    2:       v = s * (n - t) + 2;
                    3:       v = s * t + 1;
                    4:       v = s * t - 1;
                    5:       v = s * (n - t);
                    default: v = s * t;
                endcase
            end
        endcase
        return wrap0(v, n);
    endfunction

endpackage

// File: rtl/sbx_cfg.sv
module sbx_cfg
    import sbx_pkg::*;
#(
    parameter int N     = 8,
    parameter int SPF_W = 4,
    parameter int TRK_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_mode,
    input  logic [SPF_W-1:0]             cfg_spf,
    input  logic                         en_we,
    input  logic [2:0]                   en_type,
    input  logic [TRK_W-1:0]             en_track,
    input  logic                         en_val,
    output topo_e                        mode_q,
    output logic [SPF_W-1:0]             spf_q,
    output logic [NUM_CT-1:0][N-1:0]     en_q,
    output logic                         cfg_valid
);

    typedef struct packed {
        topo_e                     mode;
        logic [SPF_W-1:0]          spf;
        logic [NUM_CT-1:0][N-1:0]  en;
    } cfg_t;

    cfg_t st_d, st_q;
    logic legal_spf;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.mode = topo_e'(cfg_mode);
            st_d.spf  = cfg_spf;
        end
        if (en_we && (int'(en_type) < NUM_CT) && (int'(en_track) < N))
            st_d.en[en_type][en_track] = en_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: TOPO_SUBSET, spf: '0, en: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        legal_spf = (int'(st_q.spf) > 1) && (int'(st_q.spf) < N - 1);
        if (legal_spf && ((N % int'(st_q.spf)) == 0)) legal_spf = 1'b0;
    end

    assign mode_q    = st_q.mode;
    assign spf_q     = st_q.spf;
    assign en_q      = st_q.en;
    assign cfg_valid = (st_q.mode != TOPO_TWIST) || legal_spf;

    // R2
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mode_q == topo_e'($past(cfg_mode))) && (spf_q == $past(cfg_spf)));

    // R11
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_type < 3'd6 && int'(en_track) < N)
        |=> en_q[$past(en_type)][$past(en_track)] == $past(en_val));

    // R10
    en_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_we || en_type >= 3'd6 || int'(en_track) >= N) |=> $stable(en_q));

    // R7
    valid_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> mode_q == TOPO_TWIST);

endmodule

// File: rtl/sbx_route.sv
module sbx_route
    import sbx_pkg::*;
#(
    parameter int N     = 8,
    parameter int SPF_W = 4,
    parameter int TRK_W = 3
) (
    input  topo_e                          mode,
    input  logic [SPF_W-1:0]               spf,
    input  logic [NUM_CT-1:0][N-1:0]       en,
    input  logic                           valid,
    input  logic [NUM_SIDE-1:0][N-1:0]     in_all,
    output logic [NUM_SIDE-1:0][N-1:0]     out_all,
    output logic                           conflict
);

    logic [NUM_SIDE-1:0][N-1:0] acc;
    logic [NUM_SIDE-1:0][N-1:0] seen;
    logic                       multi;

    always_comb begin
        logic [1:0]       sa;
        logic [1:0]       sb;
        logic [TRK_W-1:0] ta;
        logic [TRK_W-1:0] tb;
        acc   = '0;
        seen  = '0;
        multi = 1'b0;
        for (int k = 0; k < NUM_CT; k++) begin
            for (int t = 0; t < N; t++) begin
                sa = 2'(ct_side_a(k));
                sb = 2'(ct_side_b(k));
                ta = TRK_W'(t);
                tb = TRK_W'(map_trk(mode, k, t, int'(spf), N));
                if (en[k][t]) begin
                    acc[sb][tb] = acc[sb][tb] | in_all[sa][ta];
                    acc[sa][ta] = acc[sa][ta] | in_all[sb][tb];
                    if (seen[sb][tb] || seen[sa][ta]) multi = 1'b1;
                    seen[sb][tb] = 1'b1;
                    seen[sa][ta] = 1'b1;
                end
            end
        end
    end

    assign out_all  = valid ? acc : '0;
    assign conflict = valid & multi;

endmodule

// File: rtl/sbx_top.sv
module sbx_top
    import sbx_pkg::*;
#(
    parameter int N     = 8,
    parameter int SPF_W = $clog2(N) + 1,
    parameter int TRK_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [SPF_W-1:0] cfg_spf,
    input  logic             en_we,
    input  logic [2:0]       en_type,
    input  logic [TRK_W-1:0] en_track,
    input  logic             en_val,
    input  logic [N-1:0]     in_w,
    input  logic [N-1:0]     in_n,
    input  logic [N-1:0]     in_e,
    input  logic [N-1:0]     in_s,
    output logic [N-1:0]     out_w,
    output logic [N-1:0]     out_n,
    output logic [N-1:0]     out_e,
    output logic [N-1:0]     out_s,
    output logic             cfg_valid,
    output logic             conflict
);

    topo_e                       mode_q;
    logic [SPF_W-1:0]            spf_q;
    logic [NUM_CT-1:0][N-1:0]    en_q;
    logic [NUM_SIDE-1:0][N-1:0]  in_all;
    logic [NUM_SIDE-1:0][N-1:0]  out_all;

    sbx_cfg #(.N(N), .SPF_W(SPF_W), .TRK_W(TRK_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_spf  (cfg_spf),
        .en_we    (en_we),
        .en_type  (en_type),
        .en_track (en_track),
        .en_val   (en_val),
        .mode_q   (mode_q),
        .spf_q    (spf_q),
        .en_q     (en_q),
        .cfg_valid(cfg_valid)
    );

    assign in_all[SD_W] = in_w;
    assign in_all[SD_N] = in_n;
    assign in_all[SD_E] = in_e;
    assign in_all[SD_S] = in_s;

    sbx_route #(.N(N), .SPF_W(SPF_W), .TRK_W(TRK_W)) u_route (
        .mode    (mode_q),
        .spf     (spf_q),
        .en      (en_q),
        .valid   (cfg_valid),
        .in_all  (in_all),
        .out_all (out_all),
        .conflict(conflict)
    );

    assign out_w = out_all[SD_W];
    assign out_n = out_all[SD_N];
    assign out_e = out_all[SD_E];
    assign out_s = out_all[SD_S];

    // R7
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (out_w == '0 && out_n == '0 && out_e == '0 &&
                        out_s == '0 && !conflict));

    // R11
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (out_w == '0 && out_n == '0 && out_e == '0 &&
                          out_s == '0 && !conflict));

endmodule

// File: tb/sbx_top_bench.sv
module sbx_top_bench;

    localparam int N     = 8;
    localparam int SPF_W = 4;
    localparam int TRK_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_mode = '0;
    logic [SPF_W-1:0] cfg_spf = '0;
    logic             en_we = 1'b0;
    logic [2:0]       en_type = '0;
    logic [TRK_W-1:0] en_track = '0;
    logic             en_val = 1'b0;
    logic [N-1:0]     in_w = '0, in_n = '0, in_e = '0, in_s = '0;
    logic [N-1:0]     out_w, out_n, out_e, out_s;
    logic             cfg_valid, conflict;

    int tests = 0;
    int fails = 0;

    // shadow configuration
    int        sh_mode = 0;
    int        sh_spf  = 0;
    logic      sh_en [6][N];
    logic [N-1:0] ex_o [4];
    logic      ex_valid;
    logic      ex_conf;

    always #4 clk = ~clk;

    sbx_top #(.N(N), .SPF_W(SPF_W), .TRK_W(TRK_W)) u_sbx_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_spf(cfg_spf), .en_we(en_we), .en_type(en_type), .en_track(en_track),
        .en_val(en_val), .in_w(in_w), .in_n(in_n), .in_e(in_e), .in_s(in_s),
        .out_w(out_w), .out_n(out_n), .out_e(out_e), .out_s(out_s),
        .cfg_valid(cfg_valid), .conflict(conflict)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 1-based value to 1..N then 0-based
    function automatic int ring(input int v);
        int x;
        x = v;
        while (x < 1) x = x + N;
        while (x > N) x = x - N;
        return x - 1;
    endfunction

    function automatic int end_a(input int k);
        int r [6] = '{0, 3, 0, 1, 0, 3};
        return r[k];
    endfunction

    function automatic int end_b(input int k);
        int r [6] = '{2, 1, 1, 2, 3, 2};
        return r[k];
    endfunction

    // mapped 0-based track from the requirement tables
    function automatic int ref_map(input int m, input int k, input int t0, input int f);
        int t;
        t = t0 + 1;
        if (m == 0) return t0;
        if (m == 1) return (k == 2 || k == 5) ? (N - t) : t0;
        if (m == 2) f = 1;
        case (k)
            0, 1: return ring(f * t);
            2:    return ring(f * (N - t) + 2);
            3:    return ring(f * t + 1);
            4:    return ring(f * t - 1);
            default: return ring(f * (N - t));
        endcase
    endfunction

    task automatic model();
        logic [N-1:0] ins [4];
        int hits [4][N];
        ins[0] = in_w; ins[1] = in_n; ins[2] = in_e; ins[3] = in_s;
        for (int s = 0; s < 4; s++) begin
            ex_o[s] = '0;
            for (int t = 0; t < N; t++) hits[s][t] = 0;
        end
        ex_valid = 1'b1;
        if (sh_mode == 3 && !(sh_spf > 1 && sh_spf < N - 1 && (N % sh_spf) != 0))
            ex_valid = 1'b0;
        ex_conf = 1'b0;
        for (int k = 0; k < 6; k++) begin
            for (int t = 0; t < N; t++) begin
                if (sh_en[k][t]) begin
                    int a, b, u;
                    a = end_a(k); b = end_b(k); u = ref_map(sh_mode, k, t, sh_spf);
                    ex_o[b][u] = ex_o[b][u] | ins[a][t];
                    ex_o[a][t] = ex_o[a][t] | ins[b][u];
                    hits[b][u]++; hits[a][t]++;
                end
            end
        end
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < N; t++) if (hits[s][t] > 1) ex_conf = 1'b1;
        if (!ex_valid) begin
            for (int s = 0; s < 4; s++) ex_o[s] = '0;
            ex_conf = 1'b0;
        end
    endtask

    task automatic compare(input string req);
        model();
        check({req, " out_w"}, 64'(out_w), 64'(ex_o[0]));
        check({req, " out_n"}, 64'(out_n), 64'(ex_o[1]));
        check({req, " out_e"}, 64'(out_e), 64'(ex_o[2]));
        check({req, " out_s"}, 64'(out_s), 64'(ex_o[3]));
        check("R7 cfg_valid", 64'(cfg_valid), 64'(ex_valid));
        check("R9 conflict", 64'(conflict), 64'(ex_conf));
    endtask

    task automatic wr_cfg(input int m, input int f);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'(m); cfg_spf = SPF_W'(f);
        @(negedge clk);
        cfg_we = 1'b0;
        sh_mode = m; sh_spf = f;
    endtask

    task automatic wr_en(input int k, input int t, input logic v);
        @(negedge clk);
        en_we = 1'b1; en_type = 3'(k); en_track = TRK_W'(t); en_val = v;
        if (k < 6 && t < N) sh_en[k][t] = v;
    endtask

    task automatic en_idle();
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 6; k++)
            for (int t = 0; t < N; t++) wr_en(k, t, 1'b0);
        en_idle();
    endtask

    task automatic set_in(input logic [N-1:0] w, n, e, s);
        in_w = w; in_n = n; in_e = e; in_s = s;
        #1;
    endtask

    function automatic string mode_req(input int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        int pos [N];
        unused_seed = $urandom(32'h5b0c);
        for (int k = 0; k < 6; k++) for (int t = 0; t < N; t++) sh_en[k][t] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_in('1, '1, '1, '1);
        // R1 reset state
        check("R1 out_w", 64'(out_w), 64'h0);
        check("R1 out_e", 64'(out_e), 64'h0);
        check("R1 cfg_valid", 64'(cfg_valid), 64'h1);
        check("R1 conflict", 64'(conflict), 64'h0);

        // R10 ignored enable writes: bad type codes
        wr_en(6, 0, 1'b1);
        wr_en(7, 3, 1'b1);
        en_idle();
        set_in('1, '1, '1, '1);
        check("R10 out_n", 64'(out_n), 64'h0);
        check("R10 out_s", 64'(out_s), 64'h0);

        // R3 subset, every type on track 3 individually
        for (int k = 0; k < 6; k++) begin
            wr_en(k, 2, 1'b1);
            en_idle();
            set_in(8'h04, 8'h04, 8'h04, 8'h04);
            compare("R3");
            wr_en(k, 2, 1'b0);
            en_idle();
        end

        // R2 config write lands on the edge; inputs change the same cycle
        wr_en(2, 0, 1'b1);
        en_idle();
        set_in(8'h01, 8'h00, 8'h00, 8'h00);
        check("R2 subset W1->N1", 64'(out_n), 64'h01);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'd1; cfg_spf = '0;
        set_in(8'h01, 8'h80, 8'h00, 8'h00);
        check("R2 before edge out_n", 64'(out_n), 64'h01);
        check("R2 before edge out_w", 64'(out_w), 64'h00);
        @(negedge clk);
        cfg_we = 1'b0; sh_mode = 1; sh_spf = 0;
        #1;
        check("R2 after edge out_n", 64'(out_n), 64'h80);
        check("R4 after edge out_w", 64'(out_w), 64'h01);

        // R11 disabled by rewrite
        wr_en(2, 0, 1'b0);
        en_idle();
        set_in('1, '1, '1, '1);
        check("R11 out_n", 64'(out_n), 64'h0);
        check("R11 out_w", 64'(out_w), 64'h0);

        // R9 two switches on W track 1 in subset mode
        wr_cfg(0, 0);
        wr_en(0, 0, 1'b1);
        wr_en(2, 0, 1'b1);
        en_idle();
        set_in(8'h00, 8'h00, 8'h01, 8'h00);
        check("R9 OR out_w", 64'(out_w), 64'h01);
        check("R9 conflict set", 64'(conflict), 64'h1);
        set_in(8'h00, 8'h01, 8'h00, 8'h00);
        check("R9 OR out_w north", 64'(out_w), 64'h01);
        clear_all();

        // R7 illegal factors with all switches on
        for (int k = 0; k < 6; k++) for (int t = 0; t < N; t++) wr_en(k, t, 1'b1);
        en_idle();
        foreach (pos[i]) pos[i] = 0;
        for (int f = 0; f < 9; f++) begin
            if (f == 3 || f == 5 || f == 6) continue;
            wr_cfg(3, f);
            set_in('1, '1, '1, '1);
            check("R7 invalid valid", 64'(cfg_valid), 64'h0);
            check("R7 invalid out_e", 64'(out_e), 64'h0);
            check("R7 invalid conflict", 64'(conflict), 64'h0);
        end
        // R7 other modes legal regardless of factor
        wr_cfg(2, 2);
        check("R7 rotation valid", 64'(cfg_valid), 64'h1);
        clear_all();

        // R8 adjacency broken by twist, factors 3 and 5
        for (int fi = 0; fi < 2; fi++) begin
            wr_cfg(3, fi == 0 ? 3 : 5);
            for (int t = 0; t < N; t++) wr_en(0, t, 1'b1);
            en_idle();
            for (int t = 0; t < N; t++) begin
                set_in(N'(1) << t, '0, '0, '0);
                pos[t] = -1;
                for (int j = 0; j < N; j++) if (out_e[j]) pos[t] = j;
                check("R8 single hit", 64'($countones(out_e)), 64'h1);
                compare("R6");
            end
            for (int t = 0; t + 1 < N; t++)
                check("R8 not adjacent",
                      64'((pos[t+1] - pos[t] == 1) || (pos[t] - pos[t+1] == 1)), 64'h0);
            clear_all();
        end

        // R5 rotation wrap corners: W-S t=1 -> N, S-E t=N -> N
        wr_cfg(2, 0);
        wr_en(4, 0, 1'b1);
        wr_en(5, N - 1, 1'b1);
        en_idle();
        set_in(8'h01, 8'h00, 8'h00, 8'h80);
        check("R5 W-S wrap", 64'(out_s), 64'h80);
        check("R5 S-E wrap", 64'(out_e), 64'h80);
        compare("R5");
        clear_all();

        // random configurations
        for (int it = 0; it < 120; it++) begin
            int m, f;
            m = int'($urandom_range(3, 0));
            f = int'($urandom_range(7, 0));
            wr_cfg(m, f);
            for (int k = 0; k < 6; k++)
                for (int t = 0; t < N; t++)
                    wr_en(k, t, ($urandom_range(99, 0) < 20));
            if (it % 4 == 0) wr_en(7, int'($urandom_range(7, 0)), 1'b1);
            en_idle();
            for (int v = 0; v < 3; v++) begin
                set_in(N'($urandom), N'($urandom), N'($urandom), N'($urandom));
                compare(mode_req(m));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule